// File: doc/BRIEF.md
# Physical Register Rename Unit

This block gives architectural register names fresh physical homes for an out-of-order core. Each cycle it accepts a group of up to `GROUP` micro-ops, default three, on a valid/ready allocate interface. In the same cycle it returns, for each slot:

- the physical registers that hold the two sources;
- a newly assigned physical destination;
- the physical register the destination replaced;
- a reorder-buffer index.

New destinations come from a bitmap free list. The lowest-numbered free register is always granted first.

Two alias tables are kept. The speculative table is written at rename. The retirement table is written only when entries leave the reorder buffer. Register values live outside this block, so retirement moves no data. When an entry retires, the block copies its new mapping into the retirement table and returns its superseded register to the free list. On a flush, the speculative table is reloaded from the retirement table. The free list is then rebuilt from the registers that table does not reference, and all in-flight entries are dropped.

Back-pressure follows these rules:

- `alloc_ready` depends only on the slot masks, the free-register count, the reorder-buffer room and `flush`. It never depends on `alloc_valid`.
- A group transfers in a cycle where `alloc_valid` and `alloc_ready` are both high.
- The rename results are combinational and valid only in that cycle.
- A stalled group may be held unchanged or withdrawn; it leaves no trace in the state.

Top module: `rn_rename_unit`

## Requirements
- R1: Out of reset, architectural register a maps to physical register a in both tables. Physical registers NUM_ARCH and upward are free. The reorder buffer is empty, and its first index is 0.
- R2: Each accepted slot with both its valid bit and its write bit set gets a destination. Destinations go to writing slots in rising slot order, each taking the lowest-numbered physical register still free. No two slots in one group get the same register.
- R3: A source lookup returns the mapping that holds after all older writing slots in the same group. If no older slot in the group writes that architectural register, it returns the speculative table entry.
- R4: `ren_prev_phys` of a writing slot is the mapping its destination architectural register had just before that slot, taking older slots in the same group into account.
- R5: Reorder-buffer indices are given out sequentially modulo ROB_DEPTH. Valid slots in rising slot order get consecutive indices. Slots whose valid bit is clear take no index.
- R6: `alloc_ready` is high exactly when all three hold: `flush` is low; the free count is at least the number of writing valid slots; and the free reorder-buffer entries number at least the number of valid slots. The whole group stalls otherwise.
- R7: `retire_num` = n retires the n oldest entries in order. For each retiring entry that writes, the retirement table takes its new mapping and its previous register becomes allocatable from the next cycle.
- R8: Retirement never alters the speculative table, so later source lookups are unchanged by it.
- R9: When `flush` is high, the cycle's retirements are applied first. Then the speculative table is set equal to the retirement table, and the free set becomes exactly the registers that table does not hold. The reorder buffer becomes empty, and indexing continues from the old tail.
- R10: A group refused with `alloc_ready` low changes no state. Presented again once accepted, it gets the results the model gives for that later state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Group present |
| alloc_ready | output | 1 | Group can be accepted |
| alloc_slot_vld | input | GROUP | Per-slot micro-op present |
| alloc_slot_wr | input | GROUP | Per-slot writes a destination |
| alloc_dst_arch | input | GROUP*AW | Destination architectural registers, slot g at [g*AW +: AW] |
| alloc_srca_arch | input | GROUP*AW | First source architectural registers |
| alloc_srcb_arch | input | GROUP*AW | Second source architectural registers |
| ren_srca_phys | output | GROUP*PW | First source physical registers |
| ren_srcb_phys | output | GROUP*PW | Second source physical registers |
| ren_dst_phys | output | GROUP*PW | Assigned destination (0 for non-writing slots) |
| ren_prev_phys | output | GROUP*PW | Superseded destination mapping |
| ren_rob_idx | output | GROUP*RW | Reorder-buffer index per slot |
| retire_num | input | GW | Entries retiring this cycle from the head |
| flush | input | 1 | Discard speculative state |

## Verification
The assertions assume that `retire_num` never exceeds the current reorder-buffer occupancy. They also assume that the caller retires entries only after they have been allocated. The bench keeps a model occupancy and clamps every requested retire count to it, including in the flush cycle. Allocation is offered freely, including while stalled or flushing. The block's own ready logic keeps the free list and reorder buffer from being overdrawn, which the free-count assertions then confirm.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int RN_GROUP_MAX = 8;

  function automatic int unsigned rn_ones(input logic [RN_GROUP_MAX-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < RN_GROUP_MAX; i++) n += v[i];
    return n;
  endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 128,
  parameter int GROUP    = 3,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int GW = $clog2(GROUP + 1),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic [NUM_PHYS-1:0]   flush_free_i,
  input  logic [GW-1:0]         take_cnt_i,
  input  logic [NUM_PHYS-1:0]   rel_mask_i,
  output logic [GROUP*PW-1:0]   pick_o,
  output logic [CW-1:0]         free_cnt_o
);
  logic [NUM_PHYS-1:0] free_q;
  logic [NUM_PHYS-1:0] init_vec;
  logic [NUM_PHYS-1:0] take_mask;
  logic [CW-1:0]       free_cnt_q;
  logic [CW-1:0]       rel_cnt;

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_init
    assign init_vec[i] = (i >= NUM_ARCH);
  end

  always_comb begin
    logic [NUM_PHYS-1:0] rem;
    logic [PW-1:0]       sel;
    logic                found;
    rem       = free_q;
    take_mask = '0;
    pick_o    = '0;
    for (int g = 0; g < GROUP; g++) begin
      sel   = '0;
      found = 1'b0;
      for (int i = NUM_PHYS - 1; i >= 0; i--) begin
        if (rem[i]) begin
          sel   = PW'(i);
          found = 1'b1;
        end
      end
      pick_o[g*PW +: PW] = sel;
      if (found) rem[sel] = 1'b0;
      if (found && (GW'(g) < take_cnt_i)) take_mask[sel] = 1'b1;
    end
  end

  assign rel_cnt    = CW'($countones(rel_mask_i));
  assign free_cnt_o = free_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q     <= init_vec;
      free_cnt_q <= CW'(NUM_PHYS - NUM_ARCH);
    end else if (flush_i) begin
      free_q     <= flush_free_i;
      free_cnt_q <= CW'(NUM_PHYS - NUM_ARCH);
    end else begin
      free_q     <= (free_q & ~take_mask) | rel_mask_i;
      free_cnt_q <= free_cnt_q - CW'(take_cnt_i) + rel_cnt;
    end
  end

  a_r7_release_was_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |-> ((rel_mask_i & free_q) == '0))
    else $error("released register was already free");

  a_r2_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt_q == CW'($countones(free_q)))
    else $error("free count disagrees with bitmap");

  a_r6_take_within: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(take_cnt_i) <= free_cnt_q)
    else $error("allocation exceeds free registers");
endmodule

// File: rtl/rn_rob_alloc.sv
module rn_rob_alloc #(
  parameter int ROB_DEPTH = 64,
  parameter int GROUP     = 3,
  parameter int AW        = 4,
  parameter int PW        = 7,
  localparam int RW  = $clog2(ROB_DEPTH),
  localparam int GW  = $clog2(GROUP + 1),
  localparam int RCW = $clog2(ROB_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [GROUP-1:0]    push_vld_i,
  input  logic [GROUP-1:0]    push_wr_i,
  input  logic [GROUP*AW-1:0] push_arch_i,
  input  logic [GROUP*PW-1:0] push_new_i,
  input  logic [GROUP*PW-1:0] push_old_i,
  input  logic [GW-1:0]       ret_cnt_i,
  output logic [GROUP*RW-1:0] slot_idx_o,
  output logic [RCW-1:0]      room_o,
  output logic [GROUP-1:0]    ret_wr_o,
  output logic [GROUP*AW-1:0] ret_arch_o,
  output logic [GROUP*PW-1:0] ret_new_o,
  output logic [GROUP*PW-1:0] ret_old_o
);
  logic          wr_q   [ROB_DEPTH];
  logic [AW-1:0] arch_q [ROB_DEPTH];
  logic [PW-1:0] new_q  [ROB_DEPTH];
  logic [PW-1:0] old_q  [ROB_DEPTH];
  logic [RW-1:0]  head_q, tail_q;
  logic [RCW-1:0] count_q;
  logic [GW-1:0]  n_push;

  assign n_push = GW'($countones(push_vld_i));
  assign room_o = RCW'(ROB_DEPTH) - count_q;

  always_comb begin
    logic [RW-1:0] off;
    off = '0;
    for (int g = 0; g < GROUP; g++) begin
      slot_idx_o[g*RW +: RW] = tail_q + off;
      if (push_vld_i[g]) off = off + 1'b1;
    end
  end

  for (genvar g = 0; g < GROUP; g++) begin : g_head
    logic [RW-1:0] e;
    assign e = head_q + RW'(g);
    assign ret_wr_o[g]            = wr_q[e];
    assign ret_arch_o[g*AW +: AW] = arch_q[e];
    assign ret_new_o[g*PW +: PW]  = new_q[e];
    assign ret_old_o[g*PW +: PW]  = old_q[e];
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < GROUP; g++) begin
      if (push_vld_i[g]) begin
        wr_q[slot_idx_o[g*RW +: RW]]   <= push_wr_i[g];
        arch_q[slot_idx_o[g*RW +: RW]] <= push_arch_i[g*AW +: AW];
        new_q[slot_idx_o[g*RW +: RW]]  <= push_new_i[g*PW +: PW];
        old_q[slot_idx_o[g*RW +: RW]]  <= push_old_i[g*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= tail_q;
      count_q <= '0;
    end else begin
      head_q  <= head_q + RW'(ret_cnt_i);
      tail_q  <= tail_q + RW'(n_push);
      count_q <= count_q + RCW'(n_push) - RCW'(ret_cnt_i);
    end
  end

  a_r7_retire_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    RCW'(ret_cnt_i) <= count_q)
    else $error("retire count exceeds occupancy");

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= RCW'(ROB_DEPTH))
    else $error("reorder buffer overfilled");
endmodule

// File: rtl/rn_map_tables.sv
module rn_map_tables #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 128,
  parameter int GROUP    = 3,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_i,
  input  logic [GROUP-1:0]       sw_en_i,
  input  logic [GROUP*AW-1:0]    sw_arch_i,
  input  logic [GROUP*PW-1:0]    sw_phys_i,
  input  logic [GROUP-1:0]       rw_en_i,
  input  logic [GROUP*AW-1:0]    rw_arch_i,
  input  logic [GROUP*PW-1:0]    rw_phys_i,
  output logic [NUM_ARCH*PW-1:0] spec_flat_o,
  output logic [NUM_PHYS-1:0]    flush_free_o
);
  logic [PW-1:0] spec_q    [NUM_ARCH];
  logic [PW-1:0] rrat_q    [NUM_ARCH];
  logic [PW-1:0] rrat_next [NUM_ARCH];
  logic [NUM_ARCH*PW-1:0] rrat_flat;

  always_comb begin
    logic [NUM_PHYS-1:0] used;
    for (int a = 0; a < NUM_ARCH; a++) rrat_next[a] = rrat_q[a];
    for (int g = 0; g < GROUP; g++)
      if (rw_en_i[g]) rrat_next[rw_arch_i[g*AW +: AW]] = rw_phys_i[g*PW +: PW];
    used = '0;
    for (int a = 0; a < NUM_ARCH; a++) used[rrat_next[a]] = 1'b1;
    flush_free_o = ~used;
  end

  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_flat
    assign spec_flat_o[a*PW +: PW] = spec_q[a];
    assign rrat_flat[a*PW +: PW]   = rrat_q[a];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        spec_q[a] <= PW'(a);
        rrat_q[a] <= PW'(a);
      end
    end else begin
      for (int a = 0; a < NUM_ARCH; a++) rrat_q[a] <= rrat_next[a];
      if (flush_i) begin
        for (int a = 0; a < NUM_ARCH; a++) spec_q[a] <= rrat_next[a];
      end else begin
        for (int g = 0; g < GROUP; g++)
          if (sw_en_i[g]) spec_q[sw_arch_i[g*AW +: AW]] <= sw_phys_i[g*PW +: PW];
      end
    end
  end

  a_r9_spec_restored: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (spec_flat_o == rrat_flat))
    else $error("speculative table not restored by flush");

  a_r8_retire_leaves_spec: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && sw_en_i == '0) |=> $stable(spec_flat_o))
    else $error("speculative table changed without rename");
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NUM_ARCH  = 16,
  parameter int NUM_PHYS  = 128,
  parameter int ROB_DEPTH = 64,
  parameter int GROUP     = 3,
  localparam int AW  = $clog2(NUM_ARCH),
  localparam int PW  = $clog2(NUM_PHYS),
  localparam int RW  = $clog2(ROB_DEPTH),
  localparam int GW  = $clog2(GROUP + 1),
  localparam int CW  = $clog2(NUM_PHYS + 1),
  localparam int RCW = $clog2(ROB_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [GROUP-1:0]    alloc_slot_vld,
  input  logic [GROUP-1:0]    alloc_slot_wr,
  input  logic [GROUP*AW-1:0] alloc_dst_arch,
  input  logic [GROUP*AW-1:0] alloc_srca_arch,
  input  logic [GROUP*AW-1:0] alloc_srcb_arch,
  output logic [GROUP*PW-1:0] ren_srca_phys,
  output logic [GROUP*PW-1:0] ren_srcb_phys,
  output logic [GROUP*PW-1:0] ren_dst_phys,
  output logic [GROUP*PW-1:0] ren_prev_phys,
  output logic [GROUP*RW-1:0] ren_rob_idx,
  input  logic [GW-1:0]       retire_num,
  input  logic                flush
);
  logic [GROUP-1:0]       wr_slots, push_vld, sw_en, rw_en, ret_wr;
  logic [GW-1:0]          n_wr, n_vld, take_cnt;
  logic [CW-1:0]          free_cnt;
  logic [RCW-1:0]         room;
  logic                   fire;
  logic [GROUP*PW-1:0]    pick_flat;
  logic [PW-1:0]          pick_arr [GROUP];
  logic [NUM_ARCH*PW-1:0] spec_flat;
  logic [PW-1:0]          spec_arr [NUM_ARCH];
  logic [NUM_PHYS-1:0]    flush_free, rel_mask;
  logic [GROUP*AW-1:0]    ret_arch;
  logic [GROUP*PW-1:0]    ret_new, ret_old;

  for (genvar g = 0; g < GROUP; g++) begin : g_pick
    assign pick_arr[g] = pick_flat[g*PW +: PW];
  end
  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_spec
    assign spec_arr[a] = spec_flat[a*PW +: PW];
  end

  assign wr_slots    = alloc_slot_vld & alloc_slot_wr;
  assign n_wr        = GW'($countones(wr_slots));
  assign n_vld       = GW'($countones(alloc_slot_vld));
  assign alloc_ready = !flush && (free_cnt >= CW'(n_wr)) && (room >= RCW'(n_vld));
  assign fire        = alloc_valid && alloc_ready;
  assign push_vld    = fire ? alloc_slot_vld : '0;
  assign sw_en       = fire ? wr_slots : '0;
  assign take_cnt    = fire ? n_wr : '0;

  // Group rename: walk the slots oldest first over a working copy of the table.
  always_comb begin
    logic [PW-1:0] work [NUM_ARCH];
    logic [AW-1:0] da;
    int            rank;
    for (int a = 0; a < NUM_ARCH; a++) work[a] = spec_arr[a];
    rank = 0;
    for (int g = 0; g < GROUP; g++) begin
      da = alloc_dst_arch[g*AW +: AW];
      ren_srca_phys[g*PW +: PW] = work[alloc_srca_arch[g*AW +: AW]];
      ren_srcb_phys[g*PW +: PW] = work[alloc_srcb_arch[g*AW +: AW]];
      ren_dst_phys[g*PW +: PW]  = '0;
      ren_prev_phys[g*PW +: PW] = work[da];
      if (wr_slots[g]) begin
        ren_dst_phys[g*PW +: PW] = pick_arr[rank];
        work[da] = pick_arr[rank];
        rank++;
      end
    end
  end

  // Retirement: head entries that write update the committed table and release.
  always_comb begin
    rel_mask = '0;
    for (int g = 0; g < GROUP; g++) begin
      rw_en[g] = (GW'(g) < retire_num) && ret_wr[g];
      if (rw_en[g]) rel_mask[ret_old[g*PW +: PW]] = 1'b1;
    end
  end

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP)) u_free (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_free_i(flush_free),
    .take_cnt_i(take_cnt), .rel_mask_i(rel_mask),
    .pick_o(pick_flat), .free_cnt_o(free_cnt));

  rn_rob_alloc #(.ROB_DEPTH(ROB_DEPTH), .GROUP(GROUP), .AW(AW), .PW(PW)) u_rob (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .push_vld_i(push_vld), .push_wr_i(alloc_slot_wr), .push_arch_i(alloc_dst_arch),
    .push_new_i(ren_dst_phys), .push_old_i(ren_prev_phys), .ret_cnt_i(retire_num),
    .slot_idx_o(ren_rob_idx), .room_o(room),
    .ret_wr_o(ret_wr), .ret_arch_o(ret_arch), .ret_new_o(ret_new), .ret_old_o(ret_old));

  rn_map_tables #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP)) u_maps (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .sw_en_i(sw_en), .sw_arch_i(alloc_dst_arch), .sw_phys_i(ren_dst_phys),
    .rw_en_i(rw_en), .rw_arch_i(ret_arch), .rw_phys_i(ret_new),
    .spec_flat_o(spec_flat), .flush_free_o(flush_free));

  for (genvar g = 0; g < GROUP; g++) begin : g_chk
    a_r4_prev_differs: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && wr_slots[g]) |-> (ren_dst_phys[g*PW +: PW] != ren_prev_phys[g*PW +: PW]))
      else $error("new destination equals superseded mapping");
    for (genvar h = g + 1; h < GROUP; h++) begin : g_pair
      a_r2_unique_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wr_slots[g] && wr_slots[h]) |->
          (ren_dst_phys[g*PW +: PW] != ren_dst_phys[h*PW +: PW]))
        else $error("duplicate destination in group");
    end
  end
endmodule

// File: tb/tb_rn_rename_unit.sv
module tb_rn_rename_unit;
  localparam int A = 8, P = 16, D = 8, G = 3;
  localparam int AW = 3, PW = 4, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic alloc_ready;
  logic [2:0] slot_vld = '0, slot_wr = '0;
  logic [8:0] dst_a = '0, sa_a = '0, sb_a = '0;
  logic [11:0] srca_p, srcb_p, dst_p, prev_p;
  logic [8:0] rob_idx;
  logic [1:0] retire_num = '0;
  logic flush = 1'b0;

  int checks = 0, failures = 0;
  int m_spec[A], m_rrat[A];
  bit m_free[P];
  int m_free_cnt, m_head, m_tail, m_cnt;
  int r_wr[D], r_arch[D], r_new[D], r_old[D];

  always #5 clk = ~clk;

  rn_rename_unit #(.NUM_ARCH(A), .NUM_PHYS(P), .ROB_DEPTH(D), .GROUP(G)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_slot_vld(slot_vld), .alloc_slot_wr(slot_wr), .alloc_dst_arch(dst_a),
    .alloc_srca_arch(sa_a), .alloc_srcb_arch(sb_a),
    .ren_srca_phys(srca_p), .ren_srcb_phys(srcb_p), .ren_dst_phys(dst_p),
    .ren_prev_phys(prev_p), .ren_rob_idx(rob_idx), .retire_num(retire_num), .flush(flush));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] vld, input logic [2:0] wr,
                      input logic [8:0] dst, input logic [8:0] sa, input logic [8:0] sb,
                      input int rn_req, input logic fl, input string tsrc, input string tdst);
    int w[A];
    bit fr[P];
    int nwr, nv, off, pk, rn, e, d;
    bit rdy, acc;
    int pe_wr[G], pe_arch[G], pe_new[G], pe_old[G];
    rn = (rn_req < m_cnt) ? rn_req : m_cnt;
    @(negedge clk);
    alloc_valid = v; slot_vld = vld; slot_wr = wr;
    dst_a = dst; sa_a = sa; sb_a = sb; retire_num = 2'(rn); flush = fl;
    #2;
    nwr = 0; nv = 0;
    for (int g = 0; g < G; g++) begin
      if (vld[g]) nv++;
      if (vld[g] && wr[g]) nwr++;
    end
    rdy = !fl && (m_free_cnt >= nwr) && ((D - m_cnt) >= nv);
    chk("R6 ready", int'(alloc_ready), int'(rdy));
    for (int a = 0; a < A; a++) w[a] = m_spec[a];
    for (int p = 0; p < P; p++) fr[p] = m_free[p];
    off = 0;
    acc = v && rdy;
    if (acc) begin
      for (int g = 0; g < G; g++) begin
        if (vld[g]) begin
          chk({tsrc, " srca"}, int'(srca_p[g*PW +: PW]), w[sa[g*AW +: AW]]);
          chk({tsrc, " srcb"}, int'(srcb_p[g*PW +: PW]), w[sb[g*AW +: AW]]);
          chk("R5 rob index", int'(rob_idx[g*RW +: RW]), (m_tail + off) % D);
          d = int'(dst[g*AW +: AW]);
          pe_wr[off] = int'(wr[g]); pe_arch[off] = d; pe_new[off] = 0; pe_old[off] = w[d];
          if (wr[g]) begin
            pk = -1;
            for (int p = P - 1; p >= 0; p--) if (fr[p]) pk = p;
            if (pk >= 0) fr[pk] = 1'b0;
            chk({tdst, " dst"}, int'(dst_p[g*PW +: PW]), pk);
            chk("R4 prev", int'(prev_p[g*PW +: PW]), w[d]);
            pe_new[off] = pk;
            w[d] = pk;
          end
          off++;
        end
      end
    end
    @(posedge clk);
    if (acc) begin
      for (int a = 0; a < A; a++) m_spec[a] = w[a];
      for (int p = 0; p < P; p++) m_free[p] = fr[p];
      for (int i = 0; i < off; i++) begin
        e = (m_tail + i) % D;
        r_wr[e] = pe_wr[i]; r_arch[e] = pe_arch[i]; r_new[e] = pe_new[i]; r_old[e] = pe_old[i];
      end
      m_tail = (m_tail + off) % D;
      m_cnt += off;
      m_free_cnt -= nwr;
    end
    for (int k = 0; k < rn; k++) begin
      e = (m_head + k) % D;
      if (r_wr[e] != 0) begin
        m_rrat[r_arch[e]] = r_new[e];
        m_free[r_old[e]] = 1'b1;
        m_free_cnt++;
      end
    end
    m_head = (m_head + rn) % D;
    m_cnt -= rn;
    if (fl) begin
      for (int p = 0; p < P; p++) m_free[p] = 1'b1;
      for (int a = 0; a < A; a++) begin
        m_spec[a] = m_rrat[a];
        m_free[m_rrat[a]] = 1'b0;
      end
      m_free_cnt = P - A;
      m_head = m_tail;
      m_cnt = 0;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < A; a++) begin m_spec[a] = a; m_rrat[a] = a; end
    for (int p = 0; p < P; p++) m_free[p] = (p >= A);
    m_free_cnt = P - A; m_head = 0; m_tail = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 ready after reset", int'(alloc_ready), 1);
    // R1: identity lookups, first index 0
    step(1, 3'b111, 3'b000, 9'o000, {3'd2, 3'd1, 3'd0}, {3'd7, 3'd6, 3'd5}, 0, 0, "R1", "R1");
    // R3: older slots in the group supply later sources; first picks are 8,9,10
    step(1, 3'b111, 3'b111, {3'd5, 3'd5, 3'd5}, {3'd5, 3'd5, 3'd5}, {3'd1, 3'd1, 3'd1},
         3, 0, "R3", "R1");
    step(1, 3'b111, 3'b111, {3'd3, 3'd2, 3'd1}, {3'd4, 3'd1, 3'd2}, {3'd5, 3'd3, 3'd0},
         0, 0, "R3", "R2");
    // R10: stalled group, retire under it, then accepted
    step(1, 3'b111, 3'b111, {3'd6, 3'd0, 3'd7}, {3'd1, 3'd0, 3'd5}, {3'd7, 3'd6, 3'd5},
         0, 0, "R10", "R10");
    step(1, 3'b111, 3'b111, {3'd6, 3'd0, 3'd7}, {3'd1, 3'd0, 3'd5}, {3'd7, 3'd6, 3'd5},
         3, 0, "R10", "R10");
    // R7: freed superseded registers are reused lowest first
    step(1, 3'b111, 3'b111, {3'd6, 3'd0, 3'd7}, {3'd1, 3'd0, 3'd5}, {3'd7, 3'd6, 3'd5},
         0, 0, "R10", "R7");
    // R8: retire only, lookups unchanged
    step(0, 3'b000, 3'b000, 9'o000, 9'o000, 9'o000, 3, 0, "R8", "R8");
    step(1, 3'b111, 3'b000, 9'o000, {3'd3, 3'd2, 3'd1}, {3'd7, 3'd6, 3'd5}, 0, 0, "R8", "R8");
    // R9: flush with retirement in the same cycle
    step(1, 3'b111, 3'b111, 9'o123, 9'o456, 9'o701, 2, 1, "R9", "R9");
    step(1, 3'b111, 3'b111, {3'd2, 3'd1, 3'd0}, {3'd3, 3'd2, 3'd1}, {3'd7, 3'd6, 3'd5},
         0, 0, "R9", "R9");
    // sweep of slot masks with arithmetic operands, periodic flushes
    for (int it = 0; it < 640; it++) begin
      logic [8:0] d9, s9, t9;
      for (int g = 0; g < G; g++) begin
        d9[g*AW +: AW] = 3'((it * 3 + g * 5) % A);
        s9[g*AW +: AW] = 3'((it + g * 7) % A);
        t9[g*AW +: AW] = 3'((it * 5 + g) % A);
      end
      step((it % 5) != 4, 3'(it % 8), 3'((it / 8) % 8), d9, s9, t9,
           (it / 3) % 4, (it % 97) == 96, (it % 97 == 0) ? "R9" : "R3", "R2");
    end
    step(0, 3'b000, 3'b000, 9'o000, 9'o000, 9'o000, 0, 1, "R9", "R9");
    step(1, 3'b111, 3'b111, {3'd7, 3'd6, 3'd5}, {3'd0, 3'd4, 3'd7}, {3'd3, 3'd2, 3'd1},
         0, 0, "R9", "R9");
    @(negedge clk);
    alloc_valid = 1'b0; flush = 1'b0; retire_num = '0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule